// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

This block sits behind the last radix-4 butterfly stage of a 64-point transform. That stage produces its results one complex sample per clock, in computation order. Computation position `p` is built from three base-4 digits as `p = k2 + 4*k1 + 16*k0`. The frequency bin that sample belongs to is the same three digits read the other way round: `m = k0 + 4*k1 + 16*k2`. The buffer takes the serial stream and re-emits every frame in bin order (bin 0 first) on a serial output with its own frame-start flag.

The buffer holds two flip-flop banks of one frame each, used in turn:

- A frame that starts with `in_head` is written into one bank in arrival order.
- Once its last sample is in, the banks swap roles.
- While the next frame fills the other bank, the completed bank is read out at digit-reversed addresses.

Back-to-back frames therefore flow with no idle cycles. A frame cut short by an early `in_head` is dropped, and the new head restarts the fill. Samples that arrive without a frame in progress are ignored.

Top module: `dr4_reorder`

## Requirements
- R1: One frame has 4^DIGITS samples (64 by default). Output cycle `j` after the output head (j = 0..63) carries, unchanged, the input sample that arrived `r` cycles after the input head. Here `r` is `j` with its three 2-bit fields placed in reverse order: r = 16*(j mod 4) + 4*((j/4) mod 4) + j/16.
- R2: Output bins 0, 1, 2 and 3 carry the input samples from positions 0, 16, 32 and 48.
- R3: Output bin 4 carries input 4, bin 5 carries input 20, bin 16 carries input 1, and bin 17 carries input 17.
- R4: `out_head` is high in the cycle that carries bin 0. That cycle is exactly 64 clock cycles after the cycle in which `in_head` was sampled high for that frame.
- R5: `out_head` is high for exactly one cycle per emitted frame and low for bins 1..63.
- R6: Frames whose heads are exactly 64 cycles apart are emitted back to back, with the next bin 0 following the previous bin 63 directly.
- R7: When `in_head` comes again before 64 samples of the current frame have arrived, that partial frame produces no output. The new head starts a fresh frame.
- R8: After reset, and in every cycle that carries no bin, `out_head` is 0 and `out_re`/`out_im` are 0.
- R9: Input samples are ignored unless a frame is in progress. This covers samples before the first `in_head` and samples after a frame's 64th sample when no new head follows.
- R10: Full-scale values of the signed DW-bit range (-8192 and +8191 for DW = 14) pass through bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_head | input | 1 | High with the first sample of an input frame |
| in_re | input | DW | Real part of the input sample, signed, 6 integer bits |
| in_im | input | DW | Imaginary part of the input sample, signed, 6 integer bits |
| out_head | output | 1 | High with bin 0 of an output frame |
| out_re | output | DW | Real part of the output bin |
| out_im | output | DW | Imaginary part of the output bin |

## Verification
The bench builds the block with DW = 14 and DIGITS = 3. This gives the full 64-entry index space, so every bin is compared against an address reversed by hand in the bench, including the named bins 0..5, 16 and 17. The 14-bit width lets one frame drive both extreme values of the output format through the buffer. Because one frame is 64 samples long, an abort at sample 30, a three-frame continuous run and long idle windows can all be placed at the exact cycle offsets where the bank swap and the read start coincide.

// File: rtl/dr4_reorder.sv
module dr4_reorder #(
  parameter int DW     = 14,
  parameter int DIGITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_head,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_head,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int AW = 2 * DIGITS;
  localparam int N  = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [2*DW-1:0] mem [2*N];

  logic          wr_run, wr_bank, rd_run;
  logic [AW-1:0] wr_cnt, rd_cnt, rd_addr, wr_addr;
  logic          wr_en, wr_last;
  logic [2*DW-1:0] rd_word;

  assign wr_en   = in_head | wr_run;
  assign wr_addr = in_head ? '0 : wr_cnt;
  assign wr_last = wr_en && (wr_addr == LAST);

  for (genvar g = 0; g < DIGITS; g++) begin : g_rev
    assign rd_addr[2*g +: 2] = rd_cnt[2*(DIGITS-1-g) +: 2];
  end

  assign rd_word = mem[{~wr_bank, rd_addr}];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_addr}] <= {in_re, in_im};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_run  <= 1'b0;
      wr_cnt  <= '0;
      wr_bank <= 1'b0;
      rd_run  <= 1'b0;
      rd_cnt  <= '0;
    end else begin
      wr_run <= wr_en && !wr_last;
      if (wr_en) wr_cnt <= wr_addr + 1'b1;
      if (wr_last) begin
        wr_bank <= ~wr_bank;
        rd_run  <= 1'b1;
        rd_cnt  <= '0;
      end else if (rd_run) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_cnt == LAST) rd_run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_head <= 1'b0;
      out_re   <= '0;
      out_im   <= '0;
    end else begin
      out_head <= rd_run && (rd_cnt == '0);
      out_re   <= rd_run ? rd_word[2*DW-1:DW] : '0;
      out_im   <= rd_run ? rd_word[DW-1:0]    : '0;
    end
  end
endmodule

module dr4_reorder_chk #(
  parameter int DW     = 14,
  parameter int DIGITS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_head,
  input logic          out_head,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im
);
  localparam int AW = 2 * DIGITS;
  localparam int N  = 1 << AW;
  localparam logic [AW:0]   FULL  = (AW+1)'(N - 1);
  localparam logic [AW:0]   TOP   = (AW+1)'(N);
  localparam logic [AW-1:0] OLAST = AW'(N - 1);

  logic [AW:0]   fill;
  logic [AW-1:0] ocnt;
  logic          frame_done;

  assign frame_done = (fill == FULL) && !in_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      ocnt <= '0;
    end else begin
      if (in_head) fill <= (AW+1)'(1);
      else if (fill != '0 && fill < TOP) fill <= fill + 1'b1;
      else fill <= '0;
      if (out_head) ocnt <= AW'(1);
      else if (ocnt != '0 && ocnt != OLAST) ocnt <= ocnt + 1'b1;
      else ocnt <= '0;
    end
  end

  assert_head_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ##2 out_head);

  assert_head_needs_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_head |-> $past(frame_done, 2));

  assert_head_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_head |=> !out_head);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_head && ocnt == '0) |-> (out_re == '0 && out_im == '0));
endmodule

bind dr4_reorder dr4_reorder_chk #(.DW(DW), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_head(in_head),
  .out_head(out_head), .out_re(out_re), .out_im(out_im)
);

// File: tb/dr4_reorder_test.sv
module dr4_reorder_test;
  localparam int DW = 14;
  localparam int DIGITS = 3;
  localparam int N = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_head = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic          out_head;
  logic [DW-1:0] out_re, out_im;

  dr4_reorder #(.DW(DW), .DIGITS(DIGITS)) uut (
    .clk(clk), .rst_n(rst_n), .in_head(in_head), .in_re(in_re), .in_im(in_im),
    .out_head(out_head), .out_re(out_re), .out_im(out_im)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit running = 1'b0, finished = 1'b0;
  string idle_req = "R8";

  typedef struct {
    int            cyc;
    bit            head;
    logic [DW-1:0] re;
    logic [DW-1:0] im;
    string         rq;
  } exp_t;
  exp_t q[$];

  function automatic logic [DW-1:0] pat(int tag, int n, bit imag);
    int v;
    if (tag == 99) v = (imag ? n[1] : n[0]) ? -8192 : 8191;
    else if (imag) v = ((tag*53 + n*97 + 5) % 16384) - 8192;
    else v = ((tag*37 + n*211) % 16384) - 8192;
    return v[DW-1:0];
  endfunction

  function automatic int rev(int m);
    return (m % 4) * 16 + ((m / 4) % 4) * 4 + m / 16;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", rq, what, cyc, act, exp);
    end
  endtask

  // driver: drives a frame (len samples) and pushes the expected bins to the scoreboard
  task automatic send(int tag, int len, bit keep, string rq);
    int c0 = 0;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if (n == 0) c0 = cyc;
      in_head = (n == 0);
      in_re = pat(tag, n, 1'b0);
      in_im = pat(tag, n, 1'b1);
    end
    if (keep) begin
      for (int m = 0; m < N; m++) begin
        exp_t e;
        e.cyc  = c0 + 65 + m;   // head sampled at edge c0+1, output 64 edges later
        e.head = (m == 0);
        e.re   = pat(tag, rev(m), 1'b0);
        e.im   = pat(tag, rev(m), 1'b1);
        if (m < 4) e.rq = "R2";
        else if (m == 4 || m == 5 || m == 16 || m == 17) e.rq = "R3";
        else e.rq = rq;
        q.push_back(e);
      end
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_head = 1'b0;
      in_re = pat(7, i + cyc, 1'b0);
      in_im = pat(8, i * 3 + cyc, 1'b1);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(e.head ? "R4" : "R5", "out_head", int'(out_head), int'(e.head));
        chk(e.rq, "out_re", int'(out_re), int'(e.re));
        chk(e.rq, "out_im", int'(out_im), int'(e.im));
      end else begin
        chk(idle_req, "idle out_head", int'(out_head), 0);
        chk(idle_req, "idle out_re", int'(out_re), 0);
        chk(idle_req, "idle out_im", int'(out_im), 0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    // R8: reset state
    chk("R8", "reset out_head", int'(out_head), 0);
    chk("R8", "reset out_re", int'(out_re), 0);
    chk("R8", "reset out_im", int'(out_im), 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    // R9: samples with no frame in progress are ignored
    idle_req = "R9";
    idle(12);

    // R1: single frame, then ignored trailing samples (R9)
    send(1, N, 1'b1, "R1");
    idle(90);

    // R7: aborted partial frame, fresh frame follows
    idle_req = "R7";
    send(2, 30, 1'b0, "R7");
    send(3, N, 1'b1, "R7");
    idle(90);

    // R6 and R10: continuous frames, one at full scale
    idle_req = "R8";
    send(4, N, 1'b1, "R6");
    send(99, N, 1'b1, "R10");
    send(5, N, 1'b1, "R6");
    idle(70);

    while (q.size() > 0) idle(1);
    idle(5);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule